// File: doc/BRIEF.md
# SAR Converter Conversion and Gate Timing Generator

This block produces the two repeating strobes that drive a fast SAR converter with a serial data output. The first strobe is the conversion start pulse. Its rising edge marks the instant at which the analog input is sampled. The second strobe is a gate window. During the window a free-running reference clock may burst out the bits of one result. The window repeats once per conversion period. It starts a programmable number of cycles after the conversion edge and stays open for as many cycles as the result has bits.

All timing is counted in cycles of the reference clock. A host writes a period, a conversion-high width, a gate offset and a result bit count through a one-cycle load strobe, then raises `enable`. The block brings each value into its legal range before using it. It then works out the sample rate the clamped period really gives, rounded to the nearest hertz, with a small sequential divider. Loads are accepted only while the generator is stopped.

Top module: `sar_cnv_timer`

## Requirements
- R1: After reset, `cnv_o`, `gate_o`, `fault_o` and `busy_o` are 0. The configuration is a period of MAX_PERIOD, a high width of DEF_HIGH, offset 0 and DEF_BITS bits. `rate_valid_o` is 1 and `rate_o` equals round(REF_HZ / MAX_PERIOD).
- R2: While running with applied period P and high width H, `cnv_o` is 1 on cycles 0 to H-1 of every P-cycle period, counted from the first running cycle.
- R3: The applied period is the loaded period clamped to the range MIN_PERIOD to MAX_PERIOD.
- R4: The applied high width is the loaded width, reduced to P-1 when it is P or more.
- R5: `gate_o` has period P. It is 1 on period cycle c exactly when ((c - O) mod P) < B, with O the applied offset and B the loaded bit count. A window that runs past the end of a period continues at the start of the next one.
- R6: A loaded offset equal to or greater than P is applied as 0.
- R7: After an accepted load, `rate_valid_o` is 0 from the next cycle until the divider finishes, at most RATE_W+1 cycles later. `rate_o` then equals floor((REF_HZ + floor(P/2)) / P).
- R8: When enabled with B = 0 or B > P, `cnv_o` is high for the first running cycle only (if H > 0), `gate_o` never rises, and from the second cycle `fault_o` is 1 with both strobes low until `enable` goes low.
- R9: Both strobes are low in every cycle after `enable` is sampled low. Each new enable restarts the period count at cycle 0.
- R10: A load made while `enable` is high or the generator has not yet returned to idle is ignored: the strobes, the period and `rate_o` keep their values. `busy_o` is set from the next cycle and is cleared once the generator is idle with `enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that loads the four configuration values |
| cfg_period | input | CFG_W | Requested conversion period in cycles |
| cfg_high | input | CFG_W | Requested conversion-high width in cycles |
| cfg_offset | input | CFG_W | Gate delay after the conversion edge in cycles |
| cfg_bits | input | CFG_W | Result bit count, which sets the gate width in cycles |
| enable | input | 1 | Runs the generator while high |
| cnv_o | output | 1 | Conversion start pulse |
| gate_o | output | 1 | Reference clock gate window |
| fault_o | output | 1 | Gate could not start, so the conversion pulse was stopped |
| busy_o | output | 1 | A load was refused because the generator was active |
| rate_o | output | RATE_W | Achieved sample rate in Hz |
| rate_valid_o | output | 1 | `rate_o` holds a finished result |

## Verification
The assertions check the invariants that must hold on every cycle. Both strobes are low after a disable and during a fault. A conversion edge only ever occurs at count zero. The count stays below the applied period, and the applied period stays inside its limits. The configuration is frozen while active, a refused load sets the busy flag, and a started division drops the valid flag. Only the bench's scenarios can show the exact pulse positions: the high width, a gate window that wraps across a period boundary, and the clamped values of period, width and offset. The same holds for the rounded rate the divider returns and for the start sequence that ends in a fault. The bench compares every cycle of each run against a model built from the requirements.

// File: rtl/sar_cnv_timer_pkg.sv
package sar_cnv_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/sar_cnv_timer_cfg.sv
module sar_cnv_timer_cfg #(
  parameter int CFG_W      = 16,
  parameter int CNT_W      = 10,
  parameter int MIN_PERIOD = 10,
  parameter int MAX_PERIOD = 1000,
  parameter int DEF_HIGH   = 4,
  parameter int DEF_BITS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             locked_i,
  input  logic [CFG_W-1:0] period_i,
  input  logic [CFG_W-1:0] high_i,
  input  logic [CFG_W-1:0] offset_i,
  input  logic [CFG_W-1:0] bits_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic [CNT_W-1:0] offset_o,
  output logic [CFG_W-1:0] bits_o,
  output logic             gate_ok_o,
  output logic             busy_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] per_next_o
);
  localparam logic [CFG_W-1:0] MIN_C = CFG_W'(MIN_PERIOD);
  localparam logic [CFG_W-1:0] MAX_C = CFG_W'(MAX_PERIOD);
  localparam bit DEF_OK = (DEF_BITS != 0) && (DEF_BITS <= MAX_PERIOD);

  logic [CFG_W-1:0] per_c;
  logic [CFG_W-1:0] high_c;
  logic [CFG_W-1:0] off_c;

  always_comb begin
    if (period_i < MIN_C)      per_c = MIN_C;
    else if (period_i > MAX_C) per_c = MAX_C;
    else                       per_c = period_i;
    high_c = (high_i >= per_c) ? per_c - 1'b1 : high_i;
    off_c  = (offset_i >= per_c) ? '0 : offset_i;
  end

  assign accept_o   = load_i && !locked_i;
  assign per_next_o = CNT_W'(per_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_o  <= CNT_W'(MAX_PERIOD);
      high_o    <= CNT_W'(DEF_HIGH);
      offset_o  <= '0;
      bits_o    <= CFG_W'(DEF_BITS);
      gate_ok_o <= DEF_OK;
      busy_o    <= 1'b0;
    end else begin
      if (accept_o) begin
        period_o  <= CNT_W'(per_c);
        high_o    <= CNT_W'(high_c);
        offset_o  <= CNT_W'(off_c);
        bits_o    <= bits_i;
        gate_ok_o <= (bits_i != '0) && (bits_i <= per_c);
      end
      if (load_i && locked_i) busy_o <= 1'b1;
      else if (!locked_i)     busy_o <= 1'b0;
    end
  end

  p_period_range_r3: assert property (@(posedge clk) disable iff (rst)
    (period_o >= CNT_W'(MIN_PERIOD)) && (period_o <= CNT_W'(MAX_PERIOD)));
  p_busy_on_refused_r10: assert property (@(posedge clk) disable iff (rst)
    (load_i && locked_i) |=> busy_o);
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    locked_i |=> ($stable(period_o) && $stable(offset_o) && $stable(bits_o)));
endmodule

// File: rtl/sar_cnv_timer_phase.sv
module sar_cnv_timer_phase
  import sar_cnv_timer_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CFG_W-1:0] bits_i,
  input  logic             gate_ok_i,
  output logic             cnv_o,
  output logic             gate_o,
  output logic             fault_o,
  output logic             locked_o
);
  tmr_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] ph;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: if (en_i) begin
        st_n  = ST_RUN;
        cnt_n = '0;
      end
      ST_RUN: begin
        if (!en_i)           st_n = ST_IDLE;
        else if (!gate_ok_i) st_n = ST_HALT;
        else cnt_n = (cnt_q == period_i - 1'b1) ? '0 : cnt_q + 1'b1;
      end
      ST_HALT: if (!en_i) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    ph = (cnt_n >= offset_i) ? cnt_n - offset_i : cnt_n + period_i - offset_i;
  end

  assign locked_o = en_i || (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cnv_o   <= 1'b0;
      gate_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      cnv_o   <= (st_n == ST_RUN) && (cnt_n < high_i);
      gate_o  <= (st_n == ST_RUN) && gate_ok_i && (CFG_W'(ph) < bits_i);
      fault_o <= (st_n == ST_HALT);
    end
  end

  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!cnv_o && !gate_o));
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!cnv_o && !gate_o));
  p_cnv_edge_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> (cnt_q == '0));
  p_count_in_period_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (cnt_q < period_i));
endmodule

// File: rtl/sar_cnv_timer_div.sv
module sar_cnv_timer_div #(
  parameter int REF_HZ     = 100_000_000,
  parameter int MAX_PERIOD = 1000,
  parameter int CNT_W      = 10,
  parameter int RATE_W     = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_div_i,
  input  logic [CNT_W-1:0]  div_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              valid_o
);
  localparam int STEP_W   = $clog2(RATE_W + 1);
  localparam int DEF_RATE = (REF_HZ + MAX_PERIOD / 2) / MAX_PERIOD;

  logic [RATE_W-1:0] quo_q;
  logic [CNT_W-1:0]  rem_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W:0]    rem2;
  logic              ge;

  always_comb begin
    rem2 = {rem_q, quo_q[RATE_W-1]};
    ge   = rem2 >= {1'b0, div_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= RATE_W'(DEF_RATE);
      rem_q  <= '0;
      step_q <= '0;
    end else if (start_i) begin
      quo_q  <= RATE_W'(REF_HZ) + RATE_W'(start_div_i >> 1);
      rem_q  <= '0;
      step_q <= STEP_W'(RATE_W);
    end else if (step_q != '0) begin
      rem_q  <= CNT_W'(ge ? rem2 - {1'b0, div_i} : rem2);
      quo_q  <= {quo_q[RATE_W-2:0], ge};
      step_q <= step_q - 1'b1;
    end
  end

  assign rate_o  = quo_q;
  assign valid_o = (step_q == '0);

  p_start_drops_valid_r7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !valid_o);
endmodule

// File: rtl/sar_cnv_timer.sv
module sar_cnv_timer #(
  parameter int REF_HZ     = 100_000_000,
  parameter int MIN_PERIOD = 10,
  parameter int MAX_PERIOD = 1000,
  parameter int CFG_W      = 16,
  parameter int DEF_HIGH   = 4,
  parameter int DEF_BITS   = 16,
  localparam int CNT_W     = $clog2(MAX_PERIOD + 1),
  localparam int RATE_W    = $clog2(REF_HZ + MAX_PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CFG_W-1:0]  cfg_period,
  input  logic [CFG_W-1:0]  cfg_high,
  input  logic [CFG_W-1:0]  cfg_offset,
  input  logic [CFG_W-1:0]  cfg_bits,
  input  logic              enable,
  output logic              cnv_o,
  output logic              gate_o,
  output logic              fault_o,
  output logic              busy_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              rate_valid_o
);
  logic [CNT_W-1:0] period_w, high_w, offset_w, per_next_w;
  logic [CFG_W-1:0] bits_w;
  logic             gate_ok_w, accept_w, locked_w;

  sar_cnv_timer_cfg #(
    .CFG_W(CFG_W), .CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD), .DEF_HIGH(DEF_HIGH), .DEF_BITS(DEF_BITS)
  ) u_cfg (
    .clk(clk), .rst(rst), .load_i(cfg_load), .locked_i(locked_w),
    .period_i(cfg_period), .high_i(cfg_high), .offset_i(cfg_offset),
    .bits_i(cfg_bits), .period_o(period_w), .high_o(high_w),
    .offset_o(offset_w), .bits_o(bits_w), .gate_ok_o(gate_ok_w),
    .busy_o(busy_o), .accept_o(accept_w), .per_next_o(per_next_w)
  );

  sar_cnv_timer_phase #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .en_i(enable), .period_i(period_w),
    .high_i(high_w), .offset_i(offset_w), .bits_i(bits_w),
    .gate_ok_i(gate_ok_w), .cnv_o(cnv_o), .gate_o(gate_o),
    .fault_o(fault_o), .locked_o(locked_w)
  );

  sar_cnv_timer_div #(
    .REF_HZ(REF_HZ), .MAX_PERIOD(MAX_PERIOD), .CNT_W(CNT_W), .RATE_W(RATE_W)
  ) u_div (
    .clk(clk), .rst(rst), .start_i(accept_w), .start_div_i(per_next_w),
    .div_i(period_w), .rate_o(rate_o), .valid_o(rate_valid_o)
  );
endmodule

// File: tb/sar_cnv_timer_tb.sv
module sar_cnv_timer_tb;
  localparam int REF_HZ = 100_000_000;
  localparam int MINP = 10;
  localparam int MAXP = 1000;
  localparam int CFG_W = 16;
  localparam int DEF_HIGH = 4;
  localparam int DEF_BITS = 16;
  localparam int RATE_W = $clog2(REF_HZ + MAXP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [CFG_W-1:0] cfg_period = '0, cfg_high = '0, cfg_offset = '0, cfg_bits = '0;
  logic enable = 1'b0;
  logic cnv_o, gate_o, fault_o, busy_o, rate_valid_o;
  logic [RATE_W-1:0] rate_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sar_cnv_timer #(.REF_HZ(REF_HZ), .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP),
    .CFG_W(CFG_W), .DEF_HIGH(DEF_HIGH), .DEF_BITS(DEF_BITS)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_period(cfg_period),
    .cfg_high(cfg_high), .cfg_offset(cfg_offset), .cfg_bits(cfg_bits),
    .enable(enable), .cnv_o(cnv_o), .gate_o(gate_o), .fault_o(fault_o),
    .busy_o(busy_o), .rate_o(rate_o), .rate_valid_o(rate_valid_o));

  function automatic int ap_period(int p);
    return (p < MINP) ? MINP : ((p > MAXP) ? MAXP : p);
  endfunction
  function automatic int ap_high(int h, int p);
    return (h >= p) ? p - 1 : h;
  endfunction
  function automatic int ap_off(int o, int p);
    return (o >= p) ? 0 : o;
  endfunction
  function automatic longint exp_rate(int p);
    return (longint'(REF_HZ) + p / 2) / p;
  endfunction
  function automatic bit exp_gate(int c, int p, int o, int b);
    int ph;
    ph = (c >= o) ? c - o : c + p - o;
    return ph < b;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int cur_p = MAXP;

  task automatic load_cfg(int p, int h, int o, int b);
    @(negedge clk);
    cfg_period = CFG_W'(p); cfg_high = CFG_W'(h);
    cfg_offset = CFG_W'(o); cfg_bits = CFG_W'(b);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R7", "rate_valid after load", rate_valid_o, 0);
    repeat (RATE_W + 2) @(negedge clk);
    cur_p = ap_period(p);
    chk("R7", "rate_valid settled", rate_valid_o, 1);
    chk("R7", "rate value", rate_o, exp_rate(cur_p));
  endtask

  // Runs ncyc cycles with the given (already loaded) request and compares
  // {fault,cnv,gate} each cycle. poke >= 0 injects a refused load (R10).
  task automatic run_check(int p, int h, int o, int b, int ncyc, int poke, string req);
    int pp, hh, oo, idx;
    bit ok;
    logic [2:0] e;
    pp = ap_period(p); hh = ap_high(h, pp); oo = ap_off(o, pp);
    ok = (b != 0) && (b <= pp);
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (poke >= 0 && k == poke + 1) begin
        cfg_load = 1'b0;
        chk("R10", "busy after refused load", busy_o, 1);
      end
      idx = k % pp;
      if (ok) e = {1'b0, idx < hh, exp_gate(idx, pp, oo, b)};
      else if (k == 0) e = {1'b0, hh > 0, 1'b0};
      else e = 3'b100;
      chk(req, $sformatf("{fault,cnv,gate} cycle %0d", k), {fault_o, cnv_o, gate_o}, e);
      if (poke >= 0 && k == poke) begin
        cfg_period = 16'd37; cfg_high = 16'd2; cfg_offset = 16'd1; cfg_bits = 16'd5;
        cfg_load = 1'b1;
      end
    end
    enable = 1'b0;
    @(negedge clk);
    chk("R9", "strobes after disable", {fault_o, cnv_o, gate_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p, h, o, b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "strobes/fault/busy", {cnv_o, gate_o, fault_o, busy_o}, 0);
    chk("R1", "rate_valid", rate_valid_o, 1);
    chk("R1", "default rate", rate_o, exp_rate(MAXP));
    // R1 default config: run once before any load
    run_check(MAXP, DEF_HIGH, 0, DEF_BITS, MAXP + 20, -1, "R1");

    // R2, R5 basic
    load_cfg(20, 4, 3, 16);
    run_check(20, 4, 3, 16, 65, -1, "R2");
    // R5 wrap across period boundary
    load_cfg(20, 6, 15, 10);
    run_check(20, 6, 15, 10, 65, -1, "R5");
    // R3 low and high clamp
    load_cfg(3, 2, 1, 8);
    run_check(3, 2, 1, 8, 35, -1, "R3");
    load_cfg(5000, 8, 0, 18);
    run_check(5000, 8, 0, 18, 2010, -1, "R3");
    // R4 high width limit
    load_cfg(20, 50, 2, 12);
    run_check(20, 50, 2, 12, 45, -1, "R4");
    // R6 offset at and above period
    load_cfg(20, 3, 20, 7);
    run_check(20, 3, 20, 7, 45, -1, "R6");
    load_cfg(20, 3, 25, 7);
    run_check(20, 3, 25, 7, 45, -1, "R6");
    // R8 gate cannot start
    load_cfg(20, 4, 0, 0);
    run_check(20, 4, 0, 0, 10, -1, "R8");
    load_cfg(20, 4, 0, 21);
    run_check(20, 4, 0, 21, 10, -1, "R8");
    // R10 refused load while running; pattern keeps old config
    load_cfg(20, 5, 4, 9);
    run_check(20, 5, 4, 9, 60, 7, "R10");
    chk("R10", "rate_valid unchanged", rate_valid_o, 1);
    chk("R10", "rate unchanged", rate_o, exp_rate(20));
    @(negedge clk);
    chk("R10", "busy cleared when idle", busy_o, 0);
    // R9 restart: same config again must start from cycle 0
    run_check(20, 5, 4, 9, 45, -1, "R9");

    // Random configurations (R2..R8)
    for (int n = 0; n < 16; n++) begin
      p = $urandom_range(1, 1100);
      h = $urandom_range(0, p + 5);
      o = $urandom_range(0, p + 3);
      b = $urandom_range(0, 24);
      load_cfg(p, h, o, b);
      run_check(p, h, o, b, 2 * ap_period(p) + 5, -1, "R5");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule